// File: doc/BRIEF.md
# SPI Frame Master with Programmable Clock Phase

This block is a synchronous serial master that moves one SPI frame of 4 to 16 bits at a time. A single-cycle load strobe with a parallel transmit word starts a frame. The block then pulls an active-low frame strobe low, runs a serial clock derived from the system clock, shifts the transmit word out most significant bit first, and shifts the receive line in. When the frame ends it raises the strobe and presents the received word together with a one-cycle done pulse.

Clock polarity and clock phase are set per frame, together with a frame-length field and a half-period divider. The serial clock never toggles right at the strobe edges. It keeps a guard interval against each strobe edge, and the length of each guard depends on the phase setting. The strobe stays low for (2N+2) half-periods, where N is the frame length. All configuration is captured at the load strobe and held until the frame ends.

Top module: `spi_frame_master`

## Requirements
- R1: `frm_n` is high when idle. It goes low on the clock edge that accepts `load` while idle, and stays low for exactly (2N+2)*H system clocks. N is the frame length (R7) and H is the half-period (R8).
- R2: With `cfg_cpha`=0, `sclk` holds its idle level for the first 2H clocks of the frame and the last H clocks, and toggles between those intervals.
- R3: With `cfg_cpha`=1, `sclk` holds its idle level for the first H clocks of the frame and the last 2H clocks, and toggles between those intervals.
- R4: The idle level of `sclk` equals `cfg_cpol`: 0 gives an idle-low clock and 1 an idle-high clock. While no frame runs, `sclk` follows `cfg_cpol` with one clock of delay.
- R5: Captures happen at the clock edges that start half-periods 2, 4, ..., 2N, counting half-periods from 0 at the falling edge of `frm_n`. When `cfg_cpol` equals `cfg_cpha`, that is the rising `sclk` edge and `mosi` changes on the falling edge. When they differ, the edges are swapped.
- R6: `mosi` carries the transmit word most significant bit first. Bit N-1 appears in the same cycle that `frm_n` falls, and each following bit appears at the starts of half-periods 3, 5, ..., 2N-1. `mosi` is 0 while `frm_n` is high.
- R7: The frame length N is `cfg_len_m1`+1. Values of `cfg_len_m1` below 3 give N=4. Only the low N bits of `tx_word` are sent.
- R8: One half-period lasts H = `cfg_half` system clocks. A value of 0 is treated as 1.
- R9: A `load` received while `busy` is high has no effect on the running frame or on its received word.
- R10: `busy` is high from the cycle `frm_n` falls until the cycle it rises. In that cycle `done` pulses for one clock, and `rx_word` holds the N captured bits right-aligned with the upper bits zero. `rx_word` keeps that value until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level / polarity |
| cfg_cpha | input | 1 | Serial clock phase select |
| cfg_len_m1 | input | 4 | Frame length minus one |
| cfg_half | input | 8 | Half-period length in system clocks |
| load | input | 1 | Start strobe, accepted only while idle |
| tx_word | input | 16 | Parallel transmit word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rx_word | output | 16 | Received word, right-aligned |
| frm_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial transmit data |
| miso | input | 1 | Serial receive data |

## Verification
A wrong half-period index or divider count shows up at once as a misplaced `sclk` edge. The reference model compares `sclk` on every cycle, so the error is reported within one half-period of where it happens. A shift register that is misaligned or stepped at the wrong time shows on `mosi` at the next bit boundary. A wrong capture point only shows when `rx_word` is compared at the end of the frame. Random `miso` values make a capture that is early or late by one edge produce a different word.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    // True when the serial clock is away from its idle level during
    // half-period idx of a frame of nb bits.
    function automatic logic half_active(input logic pha, input int unsigned idx,
                                         input int unsigned nb);
        if (!pha) return (idx % 2 == 0) && (idx >= 2) && (idx <= 2 * nb);
        else      return (idx % 2 == 1) && (idx < 2 * nb);
    endfunction

endpackage

// File: rtl/spi_fm_timer.sv
module spi_fm_timer #(
    parameter int DIVW = 8,
    parameter int IDXW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    input  logic [DIVW-1:0] hm1,
    output logic [IDXW-1:0] idx_q,
    output logic            step
);
    typedef struct packed {
        logic [DIVW-1:0] div;
        logic [IDXW-1:0] idx;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.div = '0;
            t_d.idx = '0;
        end else if (run) begin
            if (t_q.div == hm1) begin
                t_d.div = '0;
                t_d.idx = t_q.idx + IDXW'(1);
            end else begin
                t_d.div = t_q.div + DIVW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign idx_q = t_q.idx;
    assign step  = run && (t_q.div == hm1);
endmodule

// File: rtl/spi_fm_shift.sv
module spi_fm_shift #(
    parameter int DW   = 16,
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   tx_word,
    input  logic [CNTW-1:0] nbits,
    input  logic            shift,
    input  logic            capture,
    input  logic            miso,
    output logic            tx_msb,
    output logic [DW-1:0]   rx_q
);
    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } sh_s;

    sh_s s_d, s_q;
    logic [CNTW-1:0] align;

    always_comb begin
        align = CNTW'(DW) - nbits;
        s_d   = s_q;
        if (load) begin
            s_d.tx = tx_word << align;
            s_d.rx = '0;
        end else begin
            if (shift)   s_d.tx = {s_q.tx[DW-2:0], 1'b0};
            if (capture) s_d.rx = {s_q.rx[DW-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_msb = s_q.tx[DW-1];
    assign rx_q   = s_q.rx;
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
    parameter int DW   = 16,
    parameter int DIVW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_cpol,
    input  logic                  cfg_cpha,
    input  logic [$clog2(DW)-1:0] cfg_len_m1,
    input  logic [DIVW-1:0]       cfg_half,
    input  logic                  load,
    input  logic [DW-1:0]         tx_word,
    output logic                  busy,
    output logic                  done,
    output logic [DW-1:0]         rx_word,
    output logic                  frm_n,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);
    import spi_fm_pkg::*;

    localparam int LENW = $clog2(DW);
    localparam int CNTW = LENW + 1;
    localparam int IDXW = $clog2(2 * DW + 2);

    typedef struct packed {
        logic            run;
        logic            spo;
        logic            sph;
        logic [CNTW-1:0] nbits;
        logic [DIVW-1:0] hm1;
        logic            sclk;
        logic            done;
        logic [DW-1:0]   rx_out;
    } ctl_s;

    ctl_s c_d, c_q;

    logic [CNTW-1:0] len_ext, nb_cfg;
    logic [DIVW-1:0] hm1_cfg;
    logic [IDXW-1:0] idx_q, nidx, last_idx, two_n;
    logic            step, start, fin, cap_ev, shf_ev, tx_msb;
    logic [DW-1:0]   rx_sh;

    always_comb begin
        len_ext  = CNTW'(cfg_len_m1);
        nb_cfg   = ((len_ext < CNTW'(3)) ? CNTW'(3) : len_ext) + CNTW'(1);
        hm1_cfg  = (cfg_half == '0) ? '0 : cfg_half - DIVW'(1);
        start    = !c_q.run && load;
        nidx     = idx_q + IDXW'(1);
        two_n    = IDXW'({c_q.nbits, 1'b0});
        last_idx = two_n + IDXW'(1);
        fin      = step && (idx_q == last_idx);
        cap_ev   = step && !nidx[0] && (nidx >= IDXW'(2)) && (nidx <= two_n);
        shf_ev   = step && nidx[0] && (nidx >= IDXW'(3)) && (nidx < two_n);

        c_d      = c_q;
        c_d.done = 1'b0;
        if (start) begin
            c_d.run   = 1'b1;
            c_d.spo   = cfg_cpol;
            c_d.sph   = cfg_cpha;
            c_d.nbits = nb_cfg;
            c_d.hm1   = hm1_cfg;
            c_d.sclk  = cfg_cpol;
        end else if (c_q.run) begin
            if (fin) begin
                c_d.run    = 1'b0;
                c_d.done   = 1'b1;
                c_d.rx_out = rx_sh;
                c_d.sclk   = c_q.spo;
            end else if (step) begin
                c_d.sclk = c_q.spo ^ half_active(c_q.sph, int'(nidx), int'(c_q.nbits));
            end
        end else begin
            c_d.sclk = cfg_cpol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    spi_fm_timer #(.DIVW(DIVW), .IDXW(IDXW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (c_q.run),
        .hm1   (c_q.hm1),
        .idx_q (idx_q),
        .step  (step)
    );

    spi_fm_shift #(.DW(DW), .CNTW(CNTW)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .tx_word (tx_word),
        .nbits   (nb_cfg),
        .shift   (shf_ev),
        .capture (cap_ev),
        .miso    (miso),
        .tx_msb  (tx_msb),
        .rx_q    (rx_sh)
    );

    assign busy    = c_q.run;
    assign frm_n   = !c_q.run;
    assign sclk    = c_q.sclk;
    assign mosi    = c_q.run & tx_msb;
    assign done    = c_q.done;
    assign rx_word = c_q.rx_out;
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic busy,
    input logic frm_n,
    input logic sclk,
    input logic mosi,
    input logic done,
    input logic cfg_cpol
);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(frm_n));

    p_start_from_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_n) |-> ($past(load) && !$past(busy)));

    p_lead_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_n) |-> (sclk == $past(cfg_cpol)));

    p_tail_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_n) |-> $stable(sclk));

    p_mosi_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_n |-> !mosi);
endmodule

bind spi_frame_master spi_fm_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .busy     (busy),
    .frm_n    (frm_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .done     (done),
    .cfg_cpol (cfg_cpol)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [3:0]  cfg_len_m1 = 4'd7;
    logic [7:0]  cfg_half = 8'd1;
    logic        load = 1'b0;
    logic [15:0] tx_word = '0;
    logic        busy, done, frm_n, sclk, mosi;
    logic        miso = 1'b0;
    logic [15:0] rx_word;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_frame_master u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_len_m1(cfg_len_m1), .cfg_half(cfg_half), .load(load),
        .tx_word(tx_word), .busy(busy), .done(done), .rx_word(rx_word),
        .frm_n(frm_n), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Behavioural reference: elapsed clocks since frame start drive everything.
    int m_busy, m_done, m_sclk, m_spo, m_sph, m_n, m_h, m_t, m_tx, m_acc, m_rx;

    function automatic int act(input int pha, input int hh, input int n);
        if (pha == 0) return (hh % 2 == 0 && hh >= 2 && hh <= 2 * n) ? 1 : 0;
        return (hh % 2 == 1 && hh <= 2 * n - 1) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_sclk = 0; m_rx = 0; m_t = 0;
            m_spo = 0; m_sph = 0; m_n = 4; m_h = 1; m_tx = 0; m_acc = 0;
        end else begin
            m_done = 0;
            if (m_busy == 0) begin
                m_sclk = int'(cfg_cpol);
                if (load) begin
                    m_busy = 1; m_t = 0; m_acc = 0;
                    m_spo = int'(cfg_cpol); m_sph = int'(cfg_cpha);
                    m_n = (cfg_len_m1 < 3) ? 4 : int'(cfg_len_m1) + 1;   // R7
                    m_h = (cfg_half == 0) ? 1 : int'(cfg_half);          // R8
                    m_tx = int'(tx_word) & ((1 << m_n) - 1);
                end
            end else begin
                m_t = m_t + 1;
                if (m_t == (2 * m_n + 2) * m_h) begin
                    m_busy = 0; m_done = 1; m_rx = m_acc; m_sclk = m_spo;
                end else begin
                    int hh;
                    hh = m_t / m_h;
                    if (m_t % m_h == 0 && hh % 2 == 0 && hh >= 2 && hh <= 2 * m_n)
                        m_acc = (m_acc << 1) | int'(miso);
                    m_sclk = m_spo ^ act(m_sph, hh, m_n);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act_v, exp_v);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            int e_mosi;
            e_mosi = 0;
            if (m_busy != 0) begin
                int hh, bp;
                hh = m_t / m_h;
                bp = (hh < 3) ? 0 : (hh - 1) / 2;
                if (bp > m_n - 1) bp = m_n - 1;
                e_mosi = (m_tx >> (m_n - 1 - bp)) & 1;
            end
            chk("R1 frm_n", int'(frm_n), (m_busy != 0) ? 0 : 1);
            chk((m_busy == 0) ? "R4 sclk idle" : (m_sph == 0 ? "R2 sclk" : "R3 sclk"),
                int'(sclk), m_sclk);
            chk("R6 mosi", int'(mosi), e_mosi);
            chk("R10 busy", int'(busy), m_busy);
            chk("R10 done", int'(done), m_done);
            chk("R5 rx_word", int'(rx_word), m_rx);
            miso = 1'($urandom_range(0, 1));
        end
    end

    // poke > 0: issue a load that must be ignored (R9) that many cycles into the frame.
    task automatic frame(input logic pol, input logic pha, input logic [3:0] lm1,
                         input logic [7:0] hf, input logic [15:0] w, input int poke);
        int k;
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_len_m1 = lm1; cfg_half = hf;
        tx_word = w; load = 1'b1;
        @(negedge clk);
        load = 1'b0; tx_word = ~w;
        k = 0;
        while (!done && k < 2000) begin
            @(negedge clk);
            k++;
            load = (k == poke);
            if (k == poke) cfg_cpol = ~pol;
        end
        load = 1'b0; cfg_cpol = pol;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R4 R5: all four polarity/phase pairings
        for (int m = 0; m < 4; m++) begin
            frame(m[1], m[0], 4'd7, 8'd1, 16'h00A5, 0);
            frame(m[1], m[0], 4'd15, 8'd3, 16'hC3E1, 0);
            frame(m[1], m[0], 4'd4, 8'd2, 16'h0015, 0);
        end
        // R7: clamp of short lengths, high tx bits dropped
        frame(1'b0, 1'b0, 4'd0, 8'd1, 16'hFFF9, 0);
        frame(1'b1, 1'b1, 4'd2, 8'd2, 16'h1236, 0);
        frame(1'b0, 1'b1, 4'd3, 8'd1, 16'h000B, 0);
        // R8: half-period of zero behaves as one, larger divider
        frame(1'b1, 1'b0, 4'd9, 8'd0, 16'h02D3, 0);
        frame(1'b0, 1'b1, 4'd5, 8'd7, 16'h002A, 0);
        // R9: load while busy ignored
        frame(1'b0, 1'b0, 4'd11, 8'd2, 16'h0ABC, 5);
        frame(1'b1, 1'b0, 4'd7, 8'd1, 16'h005A, 10);
        // back-to-back loads with a fresh word every frame
        for (int i = 0; i < 6; i++)
            frame(i[0], i[1], 4'(i + 6), 8'(i % 3 + 1), 16'($urandom()), 0);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule